// File: doc/BRIEF.md
# Dual-Image FPGA Configuration Loader

This controller sits in a small programmable device next to a parallel flash and an FPGA. It picks one of two bitstreams held in fixed flash regions and streams the chosen one, raw and byte by byte, into the FPGA's slave-parallel configuration port. The image held in the lower region is the protected factory image, and the image held in the next region is the user image. Flash space above both regions holds application data and is never streamed.

Leaving reset starts a user-image load without any button press. A press on the factory button abandons whatever is in progress and loads the factory image. A press on the user button reloads the user image, but only once the previous load has finished or failed. Each load pulses the program line low, waits for the target to report it is ready, and then clocks out bytes on a configuration clock that this block generates. The load ends when the target raises done. If the region runs out before done rises, the load has failed.

Two LEDs show which image is running. A failed load raises an error flag and blinks both LEDs together.

Top module: `cfg_loader`

## Requirements
- R1: While reset is held, fpga_prog_n is 1, cfg_cclk is 0, and led_user, led_factory and cfg_error are all 0. After reset is released, a user-image load starts with no button press.
- R2: A debounced press of btn_factory (active high) starts a factory-image load in any state, including in the middle of a load already in progress, which is abandoned.
- R3: A debounced press of btn_user (active high) starts a user-image load only when no load is in progress. A press during a load is ignored: no new program pulse is issued and the running load completes unchanged.
- R4: A factory load streams the flash bytes at FACTORY_BASE, FACTORY_BASE+1, and so on in order. A user load does the same starting from USER_BASE. Each byte read from flash is sent unchanged.
- R5: No flash read is ever issued at an address at or above APP_BASE (0x80000 by default).
- R6: Each load holds fpga_prog_n low for at least PROG_LOW_CLKS clocks. cfg_cclk does not rise until fpga_init has gone high after the program pulse.
- R7: Each byte appears on cfg_data while cfg_cclk is low and is still stable at the rising edge of cfg_cclk. One byte takes three clocks: flash read, data setup, and clock high. The flash address advances by exactly one per byte.
- R8: When fpga_done is high, streaming stops and no further cfg_cclk rising edges occur. Afterwards exactly one LED is lit: led_user after a user load, led_factory after a factory load. Both LEDs are off while a load is in progress.
- R9: If the last byte of the region has been clocked out and fpga_done is still low, cfg_error goes high. While cfg_error is high, led_user and led_factory are equal and toggle every 2^(BLINK_W-1) clocks.
- R10: Each button is passed through a two-flop synchronizer and accepted only after it has stayed stable for DEB_CLKS clocks. A pulse shorter than that has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_factory | input | 1 | Raw factory-image button, active high |
| btn_user | input | 1 | Raw user-image button, active high |
| flash_addr | output | ADDR_W | Flash byte address |
| flash_rd | output | 1 | Flash read strobe; data is sampled at the end of this cycle |
| flash_data | input | DATA_W | Flash read data |
| fpga_prog_n | output | 1 | Target program request, active low |
| fpga_init | input | 1 | Target ready to accept configuration, high when ready |
| fpga_done | input | 1 | Target reports configuration complete |
| cfg_cclk | output | 1 | Configuration clock |
| cfg_data | output | DATA_W | Configuration data byte |
| led_user | output | 1 | User image running, or blinking on error |
| led_factory | output | 1 | Factory image running, or blinking on error |
| cfg_error | output | 1 | Region exhausted without done |

## Verification
The properties take the following for granted about the inputs:
- The target pulls fpga_init low while fpga_prog_n is low and raises it only some clocks after the program pulse ends.
- fpga_done rises only after at least one byte has been clocked in.
- flash_data is valid within the same cycle as flash_addr.

The bench's target model obeys these rules. It samples the block on the falling clock edge and reacts to every cfg_cclk rise. Button presses are held well beyond the debounce window, except for the one deliberate short glitch.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
   typedef enum logic [2:0] {
      ST_BOOT,
      ST_PULSE,
      ST_READY,
      ST_FETCH,
      ST_SETUP,
      ST_STROBE,
      ST_LIVE,
      ST_FAIL
   } ld_state_t;

   typedef enum logic {
      IMG_USER    = 1'b0,
      IMG_FACTORY = 1'b1
   } img_sel_t;

   localparam int unsigned NUM_BTN = 2;
   localparam int unsigned BTN_FAC = 0;
   localparam int unsigned BTN_USR = 1;
endpackage

// File: rtl/cfg_btn_filter.sv
module cfg_btn_filter #(
   parameter int unsigned DEB_CLKS = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   output logic press
);
   logic [1:0] sync_q;
   logic       level_q;
   logic       level_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[0], raw};
   end

   generate
      if (DEB_CLKS == 0) begin : g_nodeb
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) level_q <= 1'b0;
            else        level_q <= sync_q[1];
         end
      end else begin : g_deb
         localparam int unsigned CW = $clog2(DEB_CLKS + 1);
         logic [CW-1:0] stab_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stab_q  <= '0;
               level_q <= 1'b0;
            end else if (sync_q[1] == level_q) begin
               stab_q <= '0;
            end else if (stab_q == CW'(DEB_CLKS - 1)) begin
               stab_q  <= '0;
               level_q <= sync_q[1];
            end else begin
               stab_q <= stab_q + 1'b1;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level_d <= 1'b0;
      else        level_d <= level_q;
   end

   assign press = level_q & ~level_d;
endmodule

// File: rtl/cfg_seq.sv
module cfg_seq
   import cfg_pkg::*;
#(
   parameter int unsigned ADDR_W        = 20,
   parameter int unsigned DATA_W        = 8,
   parameter int unsigned IMG_BYTES     = 262144,
   parameter int unsigned FACTORY_BASE  = 32'h00000,
   parameter int unsigned USER_BASE     = 32'h40000,
   parameter int unsigned PROG_LOW_CLKS = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_fac,
   input  logic              start_usr,
   input  logic [DATA_W-1:0] flash_data,
   input  logic              fpga_init,
   input  logic              fpga_done,
   output logic [ADDR_W-1:0] flash_addr,
   output logic              flash_rd,
   output logic              prog_n,
   output logic              cclk,
   output logic [DATA_W-1:0] data,
   output ld_state_t         state_o,
   output img_sel_t          img_o
);
   localparam int unsigned IDX_W = (IMG_BYTES > 1) ? $clog2(IMG_BYTES) : 1;
   localparam int unsigned PCW   = $clog2(PROG_LOW_CLKS + 1);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(IMG_BYTES - 1);
   localparam logic [ADDR_W-1:0] FAC_A   = ADDR_W'(FACTORY_BASE);
   localparam logic [ADDR_W-1:0] USR_A   = ADDR_W'(USER_BASE);

   ld_state_t         st_q;
   img_sel_t          img_q;
   logic [IDX_W-1:0]  idx_q;
   logic [PCW-1:0]    pcnt_q;
   logic              accept_usr;
   logic [ADDR_W-1:0] base_a;

   assign accept_usr = start_usr && (st_q == ST_LIVE || st_q == ST_FAIL);
   assign base_a     = (img_q == IMG_FACTORY) ? FAC_A : USR_A;
   assign flash_addr = base_a + ADDR_W'(idx_q);
   assign flash_rd   = (st_q == ST_FETCH);
   assign state_o    = st_q;
   assign img_o      = img_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_BOOT;
         img_q  <= IMG_USER;
         idx_q  <= '0;
         pcnt_q <= '0;
         prog_n <= 1'b1;
         cclk   <= 1'b0;
         data   <= '0;
      end else if (start_fac || accept_usr) begin
         img_q  <= start_fac ? IMG_FACTORY : IMG_USER;
         st_q   <= ST_PULSE;
         idx_q  <= '0;
         pcnt_q <= '0;
         prog_n <= 1'b0;
         cclk   <= 1'b0;
      end else begin
         case (st_q)
            ST_BOOT: begin
               img_q  <= IMG_USER;
               st_q   <= ST_PULSE;
               idx_q  <= '0;
               pcnt_q <= '0;
               prog_n <= 1'b0;
            end
            ST_PULSE: begin
               if (pcnt_q == PCW'(PROG_LOW_CLKS - 1)) begin
                  prog_n <= 1'b1;
                  st_q   <= ST_READY;
               end else begin
                  pcnt_q <= pcnt_q + 1'b1;
               end
            end
            ST_READY: begin
               if (fpga_init) st_q <= ST_FETCH;
            end
            ST_FETCH: begin
               if (fpga_done) begin
                  st_q <= ST_LIVE;
               end else begin
                  data <= flash_data;
                  st_q <= ST_SETUP;
               end
            end
            ST_SETUP: begin
               cclk <= 1'b1;
               st_q <= ST_STROBE;
            end
            ST_STROBE: begin
               cclk <= 1'b0;
               if (fpga_done) begin
                  st_q <= ST_LIVE;
               end else if (idx_q == LAST_IDX) begin
                  st_q <= ST_FAIL;
               end else begin
                  idx_q <= idx_q + 1'b1;
                  st_q  <= ST_FETCH;
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/cfg_status.sv
module cfg_status
   import cfg_pkg::*;
#(
   parameter int unsigned BLINK_W = 22
) (
   input  logic      clk,
   input  logic      rst_n,
   input  ld_state_t state,
   input  img_sel_t  img,
   output logic      led_user,
   output logic      led_factory,
   output logic      error
);
   logic blink;
   logic live;

   generate
      if (BLINK_W <= 1) begin : g_fast
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) blink <= 1'b0;
            else        blink <= ~blink;
         end
      end else begin : g_div
         logic [BLINK_W-1:0] div_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) div_q <= '0;
            else        div_q <= div_q + 1'b1;
         end
         assign blink = div_q[BLINK_W-1];
      end
   endgenerate

   assign live        = (state == ST_LIVE);
   assign error       = (state == ST_FAIL);
   assign led_user    = (live && img == IMG_USER)    || (error && blink);
   assign led_factory = (live && img == IMG_FACTORY) || (error && blink);
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
   import cfg_pkg::*;
#(
   parameter int unsigned ADDR_W        = 20,
   parameter int unsigned DATA_W        = 8,
   parameter int unsigned IMG_BYTES     = 262144,
   parameter int unsigned FACTORY_BASE  = 32'h00000,
   parameter int unsigned USER_BASE     = 32'h40000,
   parameter int unsigned APP_BASE      = 32'h80000,
   parameter int unsigned PROG_LOW_CLKS = 8,
   parameter int unsigned DEB_CLKS      = 16,
   parameter int unsigned BLINK_W       = 22
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              btn_factory,
   input  logic              btn_user,
   output logic [ADDR_W-1:0] flash_addr,
   output logic              flash_rd,
   input  logic [DATA_W-1:0] flash_data,
   output logic              fpga_prog_n,
   input  logic              fpga_init,
   input  logic              fpga_done,
   output logic              cfg_cclk,
   output logic [DATA_W-1:0] cfg_data,
   output logic              led_user,
   output logic              led_factory,
   output logic              cfg_error
);
   initial begin
      assert (IMG_BYTES >= 2) else $error("image region too small");
      assert (PROG_LOW_CLKS >= 1) else $error("program pulse must be at least one clock");
      assert (FACTORY_BASE + IMG_BYTES <= USER_BASE || USER_BASE + IMG_BYTES <= FACTORY_BASE)
         else $error("image regions overlap");
      assert (FACTORY_BASE + IMG_BYTES <= APP_BASE && USER_BASE + IMG_BYTES <= APP_BASE)
         else $error("image region reaches application space");
      assert (APP_BASE <= (64'd1 << ADDR_W)) else $error("address width too narrow");
   end

   logic [NUM_BTN-1:0] raw_btn;
   logic [NUM_BTN-1:0] press;
   ld_state_t          state;
   img_sel_t           img;

   assign raw_btn[BTN_FAC] = btn_factory;
   assign raw_btn[BTN_USR] = btn_user;

   for (genvar b = 0; b < NUM_BTN; b++) begin : g_btn
      cfg_btn_filter #(.DEB_CLKS(DEB_CLKS)) u_filt (
         .clk   (clk),
         .rst_n (rst_n),
         .raw   (raw_btn[b]),
         .press (press[b])
      );
   end

   cfg_seq #(
      .ADDR_W        (ADDR_W),
      .DATA_W        (DATA_W),
      .IMG_BYTES     (IMG_BYTES),
      .FACTORY_BASE  (FACTORY_BASE),
      .USER_BASE     (USER_BASE),
      .PROG_LOW_CLKS (PROG_LOW_CLKS)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_fac  (press[BTN_FAC]),
      .start_usr  (press[BTN_USR]),
      .flash_data (flash_data),
      .fpga_init  (fpga_init),
      .fpga_done  (fpga_done),
      .flash_addr (flash_addr),
      .flash_rd   (flash_rd),
      .prog_n     (fpga_prog_n),
      .cclk       (cfg_cclk),
      .data       (cfg_data),
      .state_o    (state),
      .img_o      (img)
   );

   cfg_status #(.BLINK_W(BLINK_W)) u_stat (
      .clk         (clk),
      .rst_n       (rst_n),
      .state       (state),
      .img         (img),
      .led_user    (led_user),
      .led_factory (led_factory),
      .error       (cfg_error)
   );
endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk #(
   parameter int unsigned ADDR_W        = 20,
   parameter int unsigned DATA_W        = 8,
   parameter int unsigned APP_BASE      = 32'h80000,
   parameter int unsigned PROG_LOW_CLKS = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] flash_addr,
   input logic              flash_rd,
   input logic              fpga_prog_n,
   input logic              fpga_init,
   input logic              cfg_cclk,
   input logic [DATA_W-1:0] cfg_data,
   input logic              led_user,
   input logic              led_factory,
   input logic              cfg_error
);
   localparam int unsigned RW = $clog2(PROG_LOW_CLKS + 2);
   logic [RW-1:0] low_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                low_run <= '0;
      else if (fpga_prog_n)                      low_run <= '0;
      else if (low_run != RW'(PROG_LOW_CLKS + 1)) low_run <= low_run + 1'b1;
   end

   p_no_app_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
      flash_rd |-> ({1'b0, flash_addr} < (ADDR_W+1)'(APP_BASE)));

   p_prog_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fpga_prog_n) |-> (low_run >= RW'(PROG_LOW_CLKS)));

   p_cclk_after_init_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_cclk) |-> fpga_init);

   p_data_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_cclk) |-> $stable(cfg_data));

   p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_cclk |-> $stable(flash_addr));

   p_one_led_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_error |-> !(led_user && led_factory));

   p_blink_pair_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_error |-> (led_user == led_factory));
endmodule

bind cfg_loader cfg_loader_chk #(
   .ADDR_W        (ADDR_W),
   .DATA_W        (DATA_W),
   .APP_BASE      (APP_BASE),
   .PROG_LOW_CLKS (PROG_LOW_CLKS)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .flash_addr  (flash_addr),
   .flash_rd    (flash_rd),
   .fpga_prog_n (fpga_prog_n),
   .fpga_init   (fpga_init),
   .cfg_cclk    (cfg_cclk),
   .cfg_data    (cfg_data),
   .led_user    (led_user),
   .led_factory (led_factory),
   .cfg_error   (cfg_error)
);

// File: tb/test_cfg_loader.sv
`timescale 1ns/1ps
module test_cfg_loader;
   localparam int ADDR_W   = 20;
   localparam int IMG      = 16;
   localparam int FAC_B    = 'h00000;
   localparam int USR_B    = 'h40000;
   localparam int PLOW     = 3;
   localparam int DEB      = 4;
   localparam int BLW      = 3;
   localparam int INIT_DLY = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic btn_factory = 1'b0, btn_user = 1'b0;
   logic [ADDR_W-1:0] flash_addr;
   logic flash_rd;
   logic [7:0] flash_data;
   logic fpga_prog_n, fpga_init = 1'b0, fpga_done = 1'b0;
   logic cfg_cclk;
   logic [7:0] cfg_data;
   logic led_user, led_factory, cfg_error;

   always #10 clk = ~clk;

   function automatic logic [7:0] fl(input int a);
      return 8'(a) ^ ((a & 'h40000) != 0 ? 8'hA5 : 8'h00);
   endfunction

   assign flash_data = fl(int'(flash_addr));

   cfg_loader #(
      .ADDR_W(ADDR_W), .IMG_BYTES(IMG), .FACTORY_BASE(FAC_B), .USER_BASE(USR_B),
      .PROG_LOW_CLKS(PLOW), .DEB_CLKS(DEB), .BLINK_W(BLW)
   ) i_cfg_loader (
      .clk(clk), .rst_n(rst_n), .btn_factory(btn_factory), .btn_user(btn_user),
      .flash_addr(flash_addr), .flash_rd(flash_rd), .flash_data(flash_data),
      .fpga_prog_n(fpga_prog_n), .fpga_init(fpga_init), .fpga_done(fpga_done),
      .cfg_cclk(cfg_cclk), .cfg_data(cfg_data), .led_user(led_user),
      .led_factory(led_factory), .cfg_error(cfg_error)
   );

   // target model, evaluated on the falling edge
   int  nbytes = 0, bad_seq = 0, done_after = IMG, exp_base = USR_B;
   int  init_cnt = 0, prog_run = 0, last_low = 0, prog_seen = 0;
   bit  init_viol = 0;
   logic cclk_q = 1'b0, prog_q = 1'b1;

   always @(negedge clk) begin
      if (rst_n && !fpga_prog_n) begin
         if (prog_q) prog_seen++;
         fpga_init = 1'b0; fpga_done = 1'b0;
         init_cnt = 0; nbytes = 0; bad_seq = 0; init_viol = 0;
         prog_run++;
      end else if (rst_n) begin
         if (prog_run != 0) begin last_low = prog_run; prog_run = 0; end
         if (!fpga_init && prog_seen != 0) begin
            init_cnt++;
            if (init_cnt >= INIT_DLY) fpga_init = 1'b1;
         end
         if (cfg_cclk && !cclk_q) begin
            if (!fpga_init) init_viol = 1;
            if (cfg_data !== fl(exp_base + nbytes)) bad_seq++;
            nbytes++;
            if (nbytes == done_after) fpga_done = 1'b1;
         end
      end
      cclk_q = cfg_cclk;
      prog_q = fpga_prog_n;
   end

   int checks = 0, fails = 0;

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic press(input bit fac);
      @(negedge clk);
      if (fac) btn_factory = 1'b1; else btn_user = 1'b1;
      repeat (DEB + 6) @(negedge clk);
      btn_factory = 1'b0; btn_user = 1'b0;
      repeat (8) @(negedge clk);
   endtask

   task automatic wait_end(input string tag);
      int n = 0;
      while (!(led_user || led_factory || cfg_error) && n < 3000) begin
         @(negedge clk); n++;
      end
      chk({tag, " load completes"}, int'(n < 3000), 1);
   endtask

   task automatic wait_prog(input int p0, input string tag);
      int n = 0;
      while (prog_seen == p0 && n < 200) begin @(negedge clk); n++; end
      chk({tag, " program pulse issued"}, int'(prog_seen != p0), 1);
   endtask

   task automatic check_load(input string tag, input int img, input int err, input int nb);
      chk({tag, " R9 error flag"}, int'(cfg_error), err);
      if (!err) begin
         chk({tag, " R8 led_user"}, int'(led_user), int'(img == 0));
         chk({tag, " R8 led_factory"}, int'(led_factory), int'(img == 1));
      end
      chk({tag, " R8 byte count"}, nbytes, nb);
      chk({tag, " R4 R7 byte sequence"}, bad_seq, 0);
      chk({tag, " R6 program low width"}, int'(last_low >= PLOW), 1);
      chk({tag, " R6 no clock before init"}, int'(init_viol), 0);
   endtask

   // {button (1 factory, 2 user), done after N bytes, image (0 user, 1 factory), error}
   localparam int NV = 7;
   localparam int VEC [NV][4] = '{
      '{1, IMG, 1, 0},
      '{2, IMG, 0, 0},
      '{1, 5,   1, 0},
      '{2, 99,  0, 1},
      '{2, IMG, 0, 0},
      '{1, 99,  1, 1},
      '{1, 1,   1, 0}
   };

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      int p0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 prog_n in reset", int'(fpga_prog_n), 1);
      chk("R1 cclk in reset", int'(cfg_cclk), 0);
      chk("R1 leds in reset", int'(led_user | led_factory | cfg_error), 0);
      exp_base = USR_B; done_after = IMG;
      rst_n = 1'b1;
      wait_prog(0, "R1 boot");
      wait_end("R1 boot");
      check_load("R1 boot", 0, 0, IMG);

      for (int v = 0; v < NV; v++) begin
         string tag;
         tag = $sformatf("vec%0d", v);
         done_after = VEC[v][1];
         exp_base   = (VEC[v][2] == 1) ? FAC_B : USR_B;
         p0 = prog_seen;
         press(VEC[v][0] == 1);
         wait_prog(p0, VEC[v][0] == 1 ? {tag, " R2"} : {tag, " R3"});
         wait_end(tag);
         check_load(tag, VEC[v][2], VEC[v][3], VEC[v][3] ? IMG : VEC[v][1]);
         if (VEC[v][3]) begin
            int tog = 0, mism = 0;
            logic prev = led_user;
            for (int c = 0; c < 16; c++) begin
               @(negedge clk);
               if (led_user != led_factory) mism++;
               if (led_user != prev) tog++;
               prev = led_user;
            end
            chk({tag, " R9 leds blink together"}, mism, 0);
            chk({tag, " R9 blink toggles"}, int'(tog >= 2), 1);
         end
      end

      // R3: user press during a factory load is ignored
      done_after = IMG; exp_base = FAC_B;
      p0 = prog_seen;
      press(1'b1);
      wait_prog(p0, "R3 setup");
      press(1'b0);
      wait_end("R3 ignore");
      check_load("R3 ignore", 1, 0, IMG);
      chk("R3 no extra program pulse", prog_seen - p0, 1);

      // R2: factory press aborts a user load in progress
      exp_base = USR_B;
      p0 = prog_seen;
      press(1'b0);
      wait_prog(p0, "R2 setup");
      begin
         int n = 0;
         while (nbytes < 3 && n < 500) begin @(negedge clk); n++; end
      end
      p0 = prog_seen;
      @(negedge clk); btn_factory = 1'b1;
      repeat (DEB + 6) @(negedge clk);
      exp_base = FAC_B;
      btn_factory = 1'b0;
      chk("R2 abort pulse", int'(prog_seen - p0 == 1), 1);
      wait_end("R2 abort");
      check_load("R2 abort", 1, 0, IMG);

      // R10: short glitch has no effect
      p0 = prog_seen;
      @(negedge clk); btn_factory = 1'b1;
      repeat (2) @(negedge clk); btn_factory = 1'b0;
      repeat (30) @(negedge clk);
      chk("R10 glitch no pulse", prog_seen - p0, 0);
      chk("R10 glitch led kept", int'(led_factory), 1);
      chk("R10 glitch prog_n", int'(fpga_prog_n), 1);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule